// File: doc/BRIEF.md
# Address-Masked GPIO Controller with Per-Pin Interrupts

This block is an eight-pin general-purpose I/O controller on a simple word-addressed register bus with byte-wide data. Software sets each pin as an input or an output, and reaches the pin data through an address window: the address itself carries a pin-select mask. An access then touches only the pins whose select bit is set. No read-modify-write is needed to change one pin.

Each pin also has an interrupt detector. It can be set for rising edge, falling edge, either edge, high level or low level. Edge events are held in a latch until software clears them with a write-one-to-clear. Level events follow the synchronised pin directly. The block shows raw status and enabled (masked) status, and drives one interrupt line that is the OR of the masked bits. Pin inputs pass through a two-flop synchroniser before anything looks at them. Bus reads are combinational: `bus_rdata` is valid in the same cycle as the request, and reads have no side effects.

The byte offsets below are `{bus_addr, 2'b00}`.
- **Data window.** An offset below 0x400 is a data access. Offset bit n+2 selects pin n.
- **Control registers.** Offsets 0x400 to 0x41C hold the per-pin registers. Bit n always belongs to pin n.

The control register map:

| Offset | Register |
|--------|----------|
| 0x400 | Direction |
| 0x404 | Sense select |
| 0x408 | Either-edge |
| 0x40C | Polarity |
| 0x410 | Interrupt enable |
| 0x414 | Raw status |
| 0x418 | Masked status |
| 0x41C | Clear (write-only) |

Top module: `gpio_mask_ctrl`

## Requirements
- R1: After reset, all control registers and the output data register are 0. Every pin is therefore an input, interrupts are disabled, and detection is falling-edge. `pin_oe`, `pin_out` and `irq` are 0, and every register reads 0.
- R2: A write with offset bit 10 clear updates output data bit n only when offset bit n+2 is 1. Pins whose select bit is 0 keep their previous output value. `pin_out` shows the new value after the clock edge that samples the write.
- R3: A read with offset bit 10 clear returns 0 for every pin not selected by its address bit. A selected output pin returns its output data bit. A selected input pin returns its synchronised input.
- R4: The direction register (0x400) reads back what was written. Bit value 1 makes the pin an output, and `pin_oe` equals this register.
- R5: A change on `pin_in` becomes visible to data reads after exactly two rising clock edges.
- R6: In edge mode (sense bit 0) with the either-edge bit 0, polarity bit 1 latches a rising edge and polarity bit 0 latches a falling edge of the synchronised input. The raw status bit goes to 1 one edge after the synchronised value changes.
- R7: In edge mode with the either-edge bit (0x408) at 1, both edge directions latch, whatever the polarity bit holds.
- R8: With sense bit 1 (0x404), the raw status follows the synchronised level: high-active when polarity is 1 and low-active when polarity is 0. Writes to the clear register do not change it, and edges are not latched in this mode.
- R9: Raw status reads at 0x414. Masked status (0x418) equals raw AND enable (0x410). `irq` is 1 exactly when some masked bit is 1.
- R10: Writing 1 to bit n of 0x41C clears pin n's latched edge. Writing 0 has no effect. An edge detected in the same cycle as a clear wins, and the bit stays set.
- R11: The sense, either-edge, polarity and enable registers read back what was written. The clear register reads 0. Control offsets above 0x41C read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Word address, byte offset bits 10:2 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not reading |
| pin_in | input | 8 | Asynchronous pin inputs |
| pin_out | output | 8 | Output data register |
| pin_oe | output | 8 | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The bench keeps a behavioural reference model and compares it with the design on every clock. It also compares every read, targeting these corner cases:

- **Masked data accesses.** Writes through a one-pin and a two-pin mask, and a masked read. A design that ignored the address mask would overwrite or return neighbouring pins.
- **Synchroniser depth.** Reads taken in each of the three cycles after an input change catch a synchroniser one stage too short or too long.
- **Edge modes.** Each edge mode gets an edge it must ignore as well as one it must latch. Either-edge is checked against a contrary polarity bit. A wrong polarity or priority would latch the wrong pins.
- **Level mode.** A clear written while the level is still active must leave the status set.
- **Edge and clear in the same cycle.** A clear that lands on the cycle of a detected edge must not lose the event.
- **Address decode.** Unmapped control offsets must read 0, which exposes a loose decode.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    // Control register index, taken from byte offset bits [4:2] in the control region
    typedef enum logic [2:0] {
        REG_DIR   = 3'd0,
        REG_SENSE = 3'd1,
        REG_BOTH  = 3'd2,
        REG_POL   = 3'd3,
        REG_EN    = 3'd4,
        REG_RAW   = 3'd5,
        REG_MSK   = 3'd6,
        REG_CLR   = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/gpio_mask_sync.sv
module gpio_mask_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/gpio_mask_det.sv
module gpio_mask_det (
    input  logic clk,
    input  logic rst_n,
    input  logic cur_i,
    input  logic sense_i,
    input  logic both_i,
    input  logic pol_i,
    input  logic clr_i,
    output logic raw_o
);
    logic prev_q;
    logic latch_q;
    logic rise_w;
    logic fall_w;
    logic trig_w;
    logic level_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            prev_q <= cur_i;
            if (!sense_i && trig_w)
                latch_q <= 1'b1;
            else if (clr_i)
                latch_q <= 1'b0;
        end
    end

    always_comb begin
        rise_w  = cur_i & ~prev_q;
        fall_w  = ~cur_i & prev_q;
        trig_w  = both_i ? (rise_w | fall_w) : (pol_i ? rise_w : fall_w);
        level_w = pol_i ? cur_i : ~cur_i;
        raw_o   = sense_i ? level_w : latch_q;
    end

    // R6: a detected edge in edge mode is latched on the next edge
    a_r6_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense_i && trig_w) |=> latch_q);

    // R10: a clear with no competing edge empties the latch
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(trig_w && !sense_i)) |=> !latch_q);

    // R8: nothing is latched while the pin is level-sensitive
    a_r8_no_latch_in_level: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_i && !latch_q) |=> !latch_q);
endmodule

// File: rtl/gpio_mask_ctrl.sv
module gpio_mask_ctrl
    import gpio_mask_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [NPIN+2:2]   bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic              irq
);
    localparam int CTL_BIT = NPIN + 2;

    logic [NPIN-1:0] out_q, dir_q, sense_q, both_q, pol_q, en_q;
    logic [NPIN-1:0] sync_w, raw_w, msk_w, clr_w, win_mask, pin_view;
    logic            in_ctl, ctl_hit, wr_win, wr_ctl, wr_dir;
    reg_sel_e        sel;

    always_comb begin
        in_ctl   = bus_addr[CTL_BIT];
        win_mask = bus_addr[NPIN+1:2];
        ctl_hit  = in_ctl && (bus_addr[NPIN+1:5] == '0);
        sel      = reg_sel_e'(bus_addr[4:2]);
        wr_win   = bus_sel && bus_wr && !in_ctl;
        wr_ctl   = bus_sel && bus_wr && ctl_hit;
        wr_dir   = wr_ctl && (sel == REG_DIR);
        clr_w    = (wr_ctl && (sel == REG_CLR)) ? bus_wdata : '0;
        pin_view = (dir_q & out_q) | (~dir_q & sync_w);
        msk_w    = raw_w & en_q;
    end

    gpio_mask_sync #(.W(NPIN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (sync_w)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_det
        gpio_mask_det u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .cur_i   (sync_w[i]),
            .sense_i (sense_q[i]),
            .both_i  (both_q[i]),
            .pol_i   (pol_q[i]),
            .clr_i   (clr_w[i]),
            .raw_o   (raw_w[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            dir_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
            pol_q   <= '0;
            en_q    <= '0;
        end else begin
            if (wr_win)
                out_q <= (out_q & ~win_mask) | (bus_wdata & win_mask);
            if (wr_ctl) begin
                unique case (sel)
                    REG_DIR:   dir_q   <= bus_wdata;
                    REG_SENSE: sense_q <= bus_wdata;
                    REG_BOTH:  both_q  <= bus_wdata;
                    REG_POL:   pol_q   <= bus_wdata;
                    REG_EN:    en_q    <= bus_wdata;
                    REG_RAW, REG_MSK, REG_CLR: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (!in_ctl) begin
                bus_rdata = pin_view & win_mask;
            end else if (ctl_hit) begin
                unique case (sel)
                    REG_DIR:   bus_rdata = dir_q;
                    REG_SENSE: bus_rdata = sense_q;
                    REG_BOTH:  bus_rdata = both_q;
                    REG_POL:   bus_rdata = pol_q;
                    REG_EN:    bus_rdata = en_q;
                    REG_RAW:   bus_rdata = raw_w;
                    REG_MSK:   bus_rdata = msk_w;
                    REG_CLR:   bus_rdata = '0;
                endcase
            end
        end
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq     = |msk_w;

    // R2: pins outside the address mask keep their output value
    a_r2_unselected_keep: assert property (@(posedge clk) disable iff (!rst_n)
        wr_win |=> ((out_q & ~$past(win_mask)) == ($past(out_q) & ~$past(win_mask))));

    // R4: output enables move only on a direction write
    a_r4_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(pin_oe));

    // R9: with every pin disabled the interrupt line stays low
    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);
endmodule

// File: tb/tb_gpio_mask_ctrl.sv
module tb_gpio_mask_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [8:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_mask_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // Behavioural reference model
    logic [7:0] m_s1, m_s2, m_prev, m_lat, m_out, m_dir, m_sen, m_both, m_pol, m_en;

    function automatic logic [7:0] m_raw();
        return (m_sen & ((m_pol & m_s2) | (~m_pol & ~m_s2))) | (~m_sen & m_lat);
    endfunction

    function automatic logic [7:0] m_read(logic [10:0] off);
        if (!off[10]) return ((m_dir & m_out) | (~m_dir & m_s2)) & off[9:2];
        if (off[9:5] != 0) return 8'h00;
        case (off[4:2])
            3'd0: return m_dir;
            3'd1: return m_sen;
            3'd2: return m_both;
            3'd3: return m_pol;
            3'd4: return m_en;
            3'd5: return m_raw();
            3'd6: return m_raw() & m_en;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_s1, m_s2, m_prev, m_lat, m_out} = '0;
            {m_dir, m_sen, m_both, m_pol, m_en} = '0;
        end else begin
            logic [7:0] rise, fall, trig, clr, old_sen;
            logic [10:0] off;
            rise = m_s2 & ~m_prev;
            fall = ~m_s2 & m_prev;
            trig = (m_both & (rise | fall)) | (~m_both & ((m_pol & rise) | (~m_pol & fall)));
            old_sen = m_sen;
            clr = 8'h00;
            off = {bus_addr, 2'b00};
            if (bus_sel && bus_wr) begin
                if (!off[10]) m_out = (m_out & ~off[9:2]) | (bus_wdata & off[9:2]);
                else if (off[9:5] == 0) begin
                    case (off[4:2])
                        3'd0: m_dir = bus_wdata;
                        3'd1: m_sen = bus_wdata;
                        3'd2: m_both = bus_wdata;
                        3'd3: m_pol = bus_wdata;
                        3'd4: m_en = bus_wdata;
                        3'd7: clr = bus_wdata;
                        default: ;
                    endcase
                end
            end
            m_lat = (m_lat & ~clr) | (trig & ~old_sen);
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of registered outputs
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 pin_out", pin_out, m_out);
            chk("R4 pin_oe", pin_oe, m_dir);
            chk("R9 irq", {7'd0, irq}, {7'd0, |(m_raw() & m_en)});
        end
    end

    task automatic wr(logic [10:0] off, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = off[10:2]; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [10:0] off, string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = off[10:2];
        #1;
        chk(tag, bus_rdata, m_read(off));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_sel = 1'b0; bus_wr = 1'b0;
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hang expected finish");
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1: reset state
        for (int k = 0; k < 8; k++) rd(11'h400 + 11'(k * 4), "R1 reg reset");
        rd(11'h3FC, "R1 data reset");
        chk("R1 irq", {7'd0, irq}, 8'h00);
        // R4: direction
        wr(11'h400, 8'hF0);
        rd(11'h400, "R4 dir readback");
        // R2: masked writes
        wr(11'h3FC, 8'hAA);
        wr(11'h040, 8'h00);
        wr(11'h300, 8'hFF);
        chk("R2 masked write", pin_out, 8'hEA);
        rd(11'h3FC, "R3 full read");
        // R5: synchroniser depth
        @(negedge clk); pin_in = 8'h05;
        rd(11'h3FC, "R5 cycle1");
        rd(11'h3FC, "R5 cycle2");
        rd(11'h3FC, "R5 cycle3");
        rd(11'h00C, "R3 masked read");
        rd(11'h204, "R3 mixed read");
        // R6/R7: edge modes
        wr(11'h410, 8'hFF);
        wr(11'h40C, 8'h05);
        wr(11'h408, 8'h04);
        rd(11'h414, "R6 no spurious");
        @(negedge clk); pin_in = 8'h00;
        idle(4);
        rd(11'h414, "R7 both falling");
        @(negedge clk); pin_in = 8'h07;
        idle(4);
        rd(11'h414, "R6 rising");
        @(negedge clk); pin_in = 8'h05;
        idle(4);
        rd(11'h414, "R6 falling");
        rd(11'h418, "R9 masked");
        // R10: clear
        wr(11'h41C, 8'h00);
        rd(11'h414, "R10 zero clear");
        wr(11'h41C, 8'h05);
        rd(11'h414, "R10 clear");
        rd(11'h41C, "R11 clear reads zero");
        wr(11'h410, 8'h02);
        rd(11'h418, "R9 subset");
        // R8: level mode
        wr(11'h41C, 8'hFF);
        wr(11'h404, 8'h08);
        wr(11'h40C, 8'h09);
        @(negedge clk); pin_in = 8'h0D;
        idle(3);
        rd(11'h414, "R8 level high");
        wr(11'h41C, 8'h08);
        rd(11'h414, "R8 clear ignored");
        @(negedge clk); pin_in = 8'h05;
        idle(3);
        rd(11'h414, "R8 level drop");
        wr(11'h40C, 8'h01);
        rd(11'h414, "R8 low active");
        // R10: edge in the same cycle as a clear
        wr(11'h404, 8'h00);
        @(negedge clk); pin_in = 8'h04;
        idle(4);
        wr(11'h41C, 8'hFF);
        rd(11'h414, "R10 cleared");
        @(negedge clk); pin_in = 8'h05;
        @(negedge clk);
        wr(11'h41C, 8'h01);
        rd(11'h414, "R10 set wins");
        // R11: readback and unmapped
        rd(11'h404, "R11 sense");
        rd(11'h408, "R11 both");
        rd(11'h40C, "R11 polarity");
        rd(11'h410, "R11 enable");
        rd(11'h420, "R11 unmapped");
        rd(11'h7FC, "R11 unmapped high");
        idle(2);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule